// File: doc/BRIEF.md
# Double-Buffered 8-Bit PWM Timer

This block produces a pulse-width-modulated waveform on one output pin. An 8-bit up counter advances on ticks from an internal prescaler that divides the system clock by 1, 4, 16 or 64. The counter runs for a period of 2^n ticks, with n set to 6, 7 or 8, and then wraps to zero. An output flip-flop inverts when the counter reaches the duty compare value, and it inverts again at the period wrap. If software clears the flip-flop before starting, each period is low for "compare" ticks and high for the remaining ticks.

Software drives the block through a simple write port with four registers. One register starts and stops the timer. One sets the period exponent and the tick rate. One holds the duty compare value. One clears the output flip-flop, enables inversion and enables double buffering. When double buffering is on, a new duty value waits in a holding register and reaches the active compare register only at the next period wrap. This lets software change the duty cycle at any point without producing a malformed pulse.

Top module: `pwm8_dbuf_timer`

## Requirements
- R1: After reset the timer is stopped, and `pwm_out` is 0 and stays 0 until software starts it.
- R2: Register 1 bits [1:0] select the period: 0 gives 64 ticks, 1 gives 128, and 2 or 3 give 256. The counter wraps to 0 when it reaches the last count, so one high phase plus one low phase spans exactly the period.
- R3: Register 1 bits [3:2] select the tick rate: 0 ticks every system clock, 1 every 4, 2 every 16 and 3 every 64.
- R4: With the flip-flop cleared and inversion enabled, every period is low for C ticks and high for (period − C) ticks, where C is the active compare value (register 2) and 0 < C < period.
- R5: The flip-flop inverts on a compare match or on a period wrap. When both happen on the same tick (compare value 0) they cancel, and the output holds.
- R6: Register 3 bit 1 enables inversion. While it is 0, the output holds its level through matches and wraps.
- R7: Writing register 3 with bit 0 set forces `pwm_out` to 0 on the next clock. This takes priority over any toggle.
- R8: Register 0 bit 0 is run. Clearing it stops the timer and zeroes the counter and prescaler. Setting it restarts from count 0, so the first match comes C·div system clocks after the write.
- R9: With register 3 bit 2 (double buffer) at 0, a write to register 2 becomes the active compare value on the next clock, including in the middle of a period.
- R10: With the double buffer on, a write to register 2 reaches only the holding register. The active compare value changes only at a period wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 run, 1 mode, 2 duty, 3 output control |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output from the flip-flop |

## Verification
A register write takes effect at the clock edge that captures it. The first tick after a start comes div clocks later, and the flip-flop is the output register, so each edge on `pwm_out` appears exactly at a tick edge. The bench therefore never waits a fixed number of cycles for a result. Instead, it counts clock edges between output transitions, sampling 1 ns after each rising edge, and compares each count with C·div or (period − C)·div. Writes made in the middle of a period are issued from a forked process at a known negative edge, and the low time of that same period then shows whether the new compare value applied at once or waited for the wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 6;
    localparam int SEL_W  = 2;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_RUN  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] A_DUTY = 2'd2;
    localparam logic [ADDR_W-1:0] A_OUT  = 2'd3;

    localparam int B_RUN   = 0;
    localparam int B_NSEL  = 0;
    localparam int B_CSEL  = 2;
    localparam int B_CLR   = 0;
    localparam int B_INV   = 1;
    localparam int B_DBUF  = 2;

    typedef struct packed {
        logic              run;
        logic [SEL_W-1:0]  nsel;
        logic [SEL_W-1:0]  csel;
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  hold;
        logic              inv;
        logic              dbuf;
    } cfg_t;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    typedef struct packed {
        logic ff;
    } ff_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
#(
    parameter int P_PRE_W = PRE_W,
    parameter int P_SEL_W = SEL_W,
    parameter int P_STEP  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [P_SEL_W-1:0] csel,
    output logic               tick
);
    localparam int N_OPT = 1 << P_SEL_W;

    logic [P_PRE_W-1:0] term [N_OPT];

    for (genvar g = 0; g < N_OPT; g++) begin : g_term
        localparam int SH = (P_STEP * g > P_PRE_W) ? P_PRE_W : P_STEP * g;
        assign term[g] = P_PRE_W'((1 << SH) - 1);
    end

    typedef struct packed {
        logic [P_PRE_W-1:0] pre;
    } st_t;

    st_t st_d, st_q;
    logic at_term;

    always_comb begin
        st_d    = st_q;
        at_term = (st_q.pre == term[csel]);
        tick    = run && at_term;
        if (!run) begin
            st_d.pre = '0;
        end else if (at_term) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_SEL_W  = SEL_W,
    parameter int P_N_BASE = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               run_next,
    input  logic [P_SEL_W-1:0] nsel,
    input  logic [P_CNT_W-1:0] cmp_q,
    input  logic [P_CNT_W-1:0] hold_q,
    input  logic               dbuf_q,
    output logic [P_CNT_W-1:0] cnt,
    output logic               ovf,
    output logic               match
);
    localparam int N_OPT = 1 << P_SEL_W;

    logic [P_CNT_W-1:0] last [N_OPT];

    for (genvar g = 0; g < N_OPT; g++) begin : g_last
        localparam int NG = (P_N_BASE + g > P_CNT_W) ? P_CNT_W : P_N_BASE + g;
        assign last[g] = P_CNT_W'((1 << NG) - 1);
    end

    typedef struct packed {
        logic [P_CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [P_CNT_W-1:0] nxt;
    logic [P_CNT_W-1:0] cmp_eff;

    always_comb begin
        st_d    = st_q;
        ovf     = tick && (st_q.cnt >= last[nsel]);
        nxt     = ovf ? '0 : P_CNT_W'(st_q.cnt + 1'b1);
        cmp_eff = (ovf && dbuf_q) ? hold_q : cmp_q;
        match   = tick && (nxt == cmp_eff);
        if (!run_next) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = nxt;
        end
    end

    assign cnt = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovf,
    output cfg_t              cfg,
    output logic              run_next,
    output logic              clr_pulse
);
    localparam cfg_t CFG_RST = '{
        run:  1'b0,
        nsel: SEL_W'(1),
        csel: SEL_W'(2),
        cmp:  '0,
        hold: '0,
        inv:  1'b0,
        dbuf: 1'b0
    };

    cfg_t cfg_d, cfg_q;
    logic hit_run, hit_mode, hit_duty, hit_out;

    always_comb begin
        cfg_d     = cfg_q;
        hit_run   = wr_en && (wr_addr == A_RUN);
        hit_mode  = wr_en && (wr_addr == A_MODE);
        hit_duty  = wr_en && (wr_addr == A_DUTY);
        hit_out   = wr_en && (wr_addr == A_OUT);
        clr_pulse = hit_out && wr_data[B_CLR];

        if (hit_run) cfg_d.run = wr_data[B_RUN];

        if (hit_mode) begin
            cfg_d.nsel = wr_data[B_NSEL +: SEL_W];
            cfg_d.csel = wr_data[B_CSEL +: SEL_W];
        end

        if (hit_duty) cfg_d.hold = wr_data[CNT_W-1:0];

        if (hit_duty && !cfg_q.dbuf) begin
            cfg_d.cmp = wr_data[CNT_W-1:0];
        end else if (ovf && cfg_q.dbuf) begin
            cfg_d.cmp = cfg_q.hold;
        end

        if (hit_out) begin
            cfg_d.inv  = wr_data[B_INV];
            cfg_d.dbuf = wr_data[B_DBUF];
        end

        run_next = cfg_d.run;
    end

    assign cfg = cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/pwm_outff.sv
module pwm_outff
    import pwm_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic match,
    input  logic inv,
    input  logic clr,
    output logic q
);
    ff_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ff = 1'b0;
        end else if (inv && (ovf ^ match)) begin
            st_d.ff = ~st_q.ff;
        end
    end

    assign q = st_q.ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwm8_dbuf_timer.sv
module pwm8_dbuf_timer
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);
    cfg_t             cfg_w;
    logic             run_next_w;
    logic             clr_w;
    logic             tick_w;
    logic             ovf_w;
    logic             match_w;
    logic [CNT_W-1:0] cnt_w;

    pwm_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ovf       (ovf_w),
        .cfg       (cfg_w),
        .run_next  (run_next_w),
        .clr_pulse (clr_w)
    );

    pwm_prescaler #(.P_PRE_W(PRE_W), .P_SEL_W(SEL_W), .P_STEP(2)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_w.run),
        .csel  (cfg_w.csel),
        .tick  (tick_w)
    );

    pwm_counter #(.P_CNT_W(CNT_W), .P_SEL_W(SEL_W), .P_N_BASE(6)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .run_next (run_next_w),
        .nsel     (cfg_w.nsel),
        .cmp_q    (cfg_w.cmp),
        .hold_q   (cfg_w.hold),
        .dbuf_q   (cfg_w.dbuf),
        .cnt      (cnt_w),
        .ovf      (ovf_w),
        .match    (match_w)
    );

    pwm_outff u_ff (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (ovf_w),
        .match (match_w),
        .inv   (cfg_w.inv),
        .clr   (clr_w),
        .q     (pwm_out)
    );
endmodule

// File: rtl/pwm8_dbuf_timer_chk.sv
module pwm8_dbuf_timer_chk
    import pwm_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              pwm_out,
    input logic              run_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              ovf,
    input logic              match,
    input logic              inv_q,
    input logic              dbuf_q,
    input logic [CNT_W-1:0]  cmp_q
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == A_OUT) && wr_data[B_CLR];

    p_stop_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (cnt_q == '0));

    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0));

    p_hold_noinv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_q && !clr_wr) |=> $stable(pwm_out));

    p_clear_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !pwm_out);

    p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_q && (ovf != match) && !clr_wr) |=> (pwm_out != $past(pwm_out)));

    p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && match && !clr_wr) |=> $stable(pwm_out));

    p_dbuf_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_q && !ovf) |=> $stable(cmp_q));

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !$past(run_q) && !clr_wr) |=> $stable(pwm_out));
endmodule

bind pwm8_dbuf_timer pwm8_dbuf_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out),
    .run_q   (cfg_w.run),
    .cnt_q   (cnt_w),
    .ovf     (ovf_w),
    .match   (match_w),
    .inv_q   (cfg_w.inv),
    .dbuf_q  (cfg_w.dbuf),
    .cmp_q   (cfg_w.cmp)
);

// File: tb/tb_pwm8_dbuf_timer.sv
module tb_pwm8_dbuf_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm8_dbuf_timer dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    typedef struct packed {
        logic [1:0] nsel;
        logic [1:0] csel;
        logic [7:0] duty;
        int         low;
        int         high;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd2, 8'h5A, 1440, 608},
        '{2'd0, 2'd0, 8'd20,   20,  44},
        '{2'd2, 2'd1, 8'd200, 800, 224},
        '{2'd0, 2'd3, 8'd1,    64, 4032},
        '{2'd3, 2'd0, 8'd255, 255,   1},
        '{2'd1, 2'd1, 8'd127, 508,   4}
    };

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_level(input logic lvl, input int limit, output int n);
        n = 0;
        while (n < limit) begin
            @(posedge clk);
            #1;
            n++;
            if (pwm_out == lvl) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset
        check_eq("R1", int'(pwm_out), 0);
        wait_level(1'b1, 100, n);
        check_eq("R1", n, 100);

        // Vector table: R2 R3 R4 R8
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd0, 8'h00);
            reg_write(2'd1, {4'b0, VECS[i].csel, VECS[i].nsel});
            reg_write(2'd2, VECS[i].duty);
            reg_write(2'd3, 8'h03);
            reg_write(2'd0, 8'h01);
            wait_level(1'b1, 6000, n);
            check_eq("R8", n, VECS[i].low);
            begin
                int hi, lo;
                wait_level(1'b0, 6000, hi);
                check_eq("R3", hi, VECS[i].high);
                wait_level(1'b1, 6000, lo);
                check_eq("R4", lo, VECS[i].low);
                check_eq("R2", hi + lo, VECS[i].low + VECS[i].high);
            end
        end

        // R5: compare 0 makes match and wrap coincide, output holds low
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'h00);
        reg_write(2'd3, 8'h03);
        reg_write(2'd0, 8'h01);
        wait_level(1'b1, 300, n);
        check_eq("R5", n, 300);

        // R6 / R7: inversion off holds level, clear forces low
        reg_write(2'd0, 8'h00);
        reg_write(2'd2, 8'd20);
        reg_write(2'd3, 8'h03);
        reg_write(2'd0, 8'h01);
        wait_level(1'b1, 300, n);
        check_eq("R4", n, 20);
        reg_write(2'd3, 8'h00);
        wait_level(1'b0, 300, n);
        check_eq("R6", n, 300);
        reg_write(2'd3, 8'h01);
        check_eq("R7", int'(pwm_out), 0);
        wait_level(1'b1, 300, n);
        check_eq("R6", n, 300);

        // R10: double buffer defers a mid-period duty change
        reg_write(2'd0, 8'h00);
        reg_write(2'd1, 8'h04);
        reg_write(2'd2, 8'd10);
        reg_write(2'd3, 8'h03);
        reg_write(2'd0, 8'h01);
        wait_level(1'b1, 2000, n);
        check_eq("R8", n, 40);
        reg_write(2'd3, 8'h06);
        wait_level(1'b0, 2000, n);
        fork
            begin
                repeat (8) @(negedge clk);
                reg_write(2'd2, 8'd30);
            end
            wait_level(1'b1, 2000, n);
        join
        check_eq("R10", n, 40);
        wait_level(1'b0, 2000, n);
        check_eq("R10", n, 216);
        wait_level(1'b1, 2000, n);
        check_eq("R10", n, 120);

        // R9: without the buffer a mid-period write applies at once
        reg_write(2'd3, 8'h02);
        wait_level(1'b0, 2000, n);
        fork
            begin
                repeat (8) @(negedge clk);
                reg_write(2'd2, 8'd10);
            end
            wait_level(1'b1, 2000, n);
        join
        check_eq("R9", n, 40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule